// File: doc/BRIEF.md
# Bit-Band Alias Bus Bridge

This bridge sits between a simple memory-mapped bus master and a memory of 32-bit words. There are two bit regions of 1 MB each: one at 0x20000000 in SRAM space and one at 0x40000000 in peripheral space. Each bit of a region is given its own 32-bit word in a 32 MB alias window. The SRAM alias window starts at 0x22000000 and the peripheral alias window at 0x42000000. A read of an alias word returns one bit of memory as 0 or 1. A write to an alias word sets or clears that one bit through a read-modify-write that holds the downstream bus locked, so no other agent can slip an update in between the read and the write.

Any other address goes to the memory unchanged. This includes addresses inside the bit regions themselves, which act as ordinary word storage.

A finite-state machine steers each request through six states: `ST_IDLE`, `ST_FORWARD`, `ST_FETCH`, `ST_MODIFY`, `ST_DONE` and `ST_FAULT`.

- **`ST_IDLE`** takes a request:
  - an alias hit with nonzero low address bits goes to `ST_FAULT`;
  - any other alias hit goes to `ST_FETCH`;
  - everything else goes to `ST_FORWARD`.
- **`ST_FORWARD`** goes to `ST_DONE` on downstream ready.
- **`ST_FETCH`** goes to `ST_MODIFY` on ready for a write, or to `ST_DONE` for a read.
- **`ST_MODIFY`** goes to `ST_DONE` on ready.
- **`ST_DONE`** and **`ST_FAULT`** each give one cycle of upstream ready and return to `ST_IDLE`.

Top module: `bb_bridge`

## Requirements
- R1: Alias address mapping. An alias address equal to alias base + byte offset×32 + bit×4 targets bit (byte offset mod 4)×8 + bit of the word at region base + (byte offset with its two low bits cleared). The pairs are SRAM 0x20000000 with alias 0x22000000 and peripheral 0x40000000 with alias 0x42000000. Each region is 1 MB and each alias window is 32 MB.
- R2: An alias read returns the target bit in s_rdata bit 0 with all other bits zero, and makes no downstream write.
- R3: An alias write uses only bit 0 of s_wdata: 1 sets the target bit and 0 clears it. Every other bit of the word keeps its value.
- R4: A byte alias access (s_byte = 1) and a word alias access (s_byte = 0) have the same single-bit effect.
- R5: For an alias write, m_lock is high from the start of the downstream read until the downstream write completes, with no unlocked cycle between them. The lock drops only after a completed write.
- R6: An address outside both alias windows, including addresses in a bit region, is forwarded with its address, direction, data and byte flag unchanged. Downstream read data is returned as is, and the request stays stable until m_ready.
- R7: An alias address with nonzero bits [1:0] returns s_err = 1 together with s_ready and makes no downstream access.
- R8: Each request gets exactly one single-cycle s_ready pulse. A request held high across a completion is taken as a new request only after that completion.
- R9: After reset, s_ready, s_err, m_req and m_lock are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_req | input | 1 | Upstream request, held until s_ready |
| s_we | input | 1 | Upstream write (1) or read (0) |
| s_byte | input | 1 | Upstream byte-sized (1) or word-sized (0) access |
| s_addr | input | 32 | Upstream byte address |
| s_wdata | input | 32 | Upstream write data |
| s_ready | output | 1 | One-cycle completion pulse |
| s_rdata | output | 32 | Read data, valid with s_ready |
| s_err | output | 1 | Error flag, valid with s_ready |
| m_req | output | 1 | Downstream request, held until m_ready |
| m_we | output | 1 | Downstream write (1) or read (0) |
| m_byte | output | 1 | Downstream byte flag (forwarded accesses only) |
| m_lock | output | 1 | Downstream bus lock during an alias read-modify-write |
| m_addr | output | 32 | Downstream address |
| m_wdata | output | 32 | Downstream write data |
| m_ready | input | 1 | Downstream completion pulse |
| m_rdata | input | 32 | Downstream read data, valid with m_ready |

## Verification
Two functions can meet in the same cycle:

- **The locked read-modify-write and a competing update.** A second agent writes a different bit of the same word. The bench's memory model, which represents that agent, lets this second write through in any cycle where m_lock is low, even while the bridge still has its own access pending. The bench arms this write as soon as m_lock first rises. It then judges the outcome by reading the word back, which must contain both bits, and by counting requested cycles in which m_lock was low, which must be zero.
- **A completion and the next request.** s_req stays high with new fields in the cycle s_ready is seen. The bench checks that s_ready drops for a cycle and that the second request then completes with its own result.

// File: rtl/bb_pkg.sv
package bb_pkg;

    localparam int BB_AW = 32;
    localparam int BB_DW = 32;
    localparam int BB_IW = $clog2(BB_DW);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FORWARD,
        ST_FETCH,
        ST_MODIFY,
        ST_DONE,
        ST_FAULT
    } bb_state_e;

    typedef struct packed {
        logic             alias_hit;
        logic             misaligned;
        logic [BB_AW-1:0] word_addr;
        logic [BB_IW-1:0] bit_idx;
    } bb_decode_t;

endpackage

// File: rtl/bb_alias_decode.sv
module bb_alias_decode
    import bb_pkg::*;
#(
    parameter int               REGION_AW    = 20,
    parameter logic [BB_AW-1:0] REGION_BASE0 = 32'h2000_0000,
    parameter logic [BB_AW-1:0] ALIAS_BASE0  = 32'h2200_0000,
    parameter logic [BB_AW-1:0] REGION_BASE1 = 32'h4000_0000,
    parameter logic [BB_AW-1:0] ALIAS_BASE1  = 32'h4200_0000
) (
    input  logic [BB_AW-1:0] addr,
    output bb_decode_t       dec
);

    localparam int NWIN     = 2;
    localparam int ALIAS_AW = REGION_AW + BB_IW;
    localparam int WORD_LO  = BB_IW + 2;

    localparam logic [NWIN-1:0][BB_AW-1:0] REGION_B = {REGION_BASE1, REGION_BASE0};
    localparam logic [NWIN-1:0][BB_AW-1:0] ALIAS_B  = {ALIAS_BASE1, ALIAS_BASE0};

    logic [NWIN-1:0]            hit;
    logic [NWIN-1:0][BB_AW-1:0] target;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        assign hit[g]    = (addr[BB_AW-1:ALIAS_AW] == ALIAS_B[g][BB_AW-1:ALIAS_AW]);
        assign target[g] = REGION_B[g] + BB_AW'({addr[ALIAS_AW-1:WORD_LO], 2'b00});
    end

    always_comb begin
        dec           = '0;
        dec.bit_idx   = addr[WORD_LO-1:2];
        for (int w = 0; w < NWIN; w++) begin
            if (hit[w]) begin
                dec.alias_hit = 1'b1;
                dec.word_addr = target[w];
            end
        end
        dec.misaligned = dec.alias_hit && (addr[1:0] != 2'b00);
    end

endmodule

// File: rtl/bb_bit_lane.sv
module bb_bit_lane
    import bb_pkg::*;
(
    input  logic [BB_DW-1:0] word_in,
    input  logic [BB_IW-1:0] idx,
    input  logic             new_val,
    output logic [BB_DW-1:0] picked,
    output logic [BB_DW-1:0] merged
);

    always_comb begin
        picked      = '0;
        picked[0]   = word_in[idx];
        merged      = word_in;
        merged[idx] = new_val;
    end

endmodule

// File: rtl/bb_bridge.sv
module bb_bridge
    import bb_pkg::*;
#(
    parameter int               REGION_AW    = 20,
    parameter logic [BB_AW-1:0] REGION_BASE0 = 32'h2000_0000,
    parameter logic [BB_AW-1:0] ALIAS_BASE0  = 32'h2200_0000,
    parameter logic [BB_AW-1:0] REGION_BASE1 = 32'h4000_0000,
    parameter logic [BB_AW-1:0] ALIAS_BASE1  = 32'h4200_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_req,
    input  logic             s_we,
    input  logic             s_byte,
    input  logic [BB_AW-1:0] s_addr,
    input  logic [BB_DW-1:0] s_wdata,
    output logic             s_ready,
    output logic [BB_DW-1:0] s_rdata,
    output logic             s_err,
    output logic             m_req,
    output logic             m_we,
    output logic             m_byte,
    output logic             m_lock,
    output logic [BB_AW-1:0] m_addr,
    output logic [BB_DW-1:0] m_wdata,
    input  logic             m_ready,
    input  logic [BB_DW-1:0] m_rdata
);

    bb_state_e state, state_nx;

    bb_decode_t       dec;
    logic [BB_AW-1:0] cap_addr;
    logic [BB_AW-1:0] cap_word;
    logic [BB_IW-1:0] cap_idx;
    logic             cap_we;
    logic             cap_byte;
    logic [BB_DW-1:0] cap_wdata;
    logic [BB_DW-1:0] hold;
    logic [BB_DW-1:0] resp;
    logic [BB_DW-1:0] lane_word;
    logic [BB_DW-1:0] lane_pick;
    logic [BB_DW-1:0] lane_merge;

    bb_alias_decode #(
        .REGION_AW    (REGION_AW),
        .REGION_BASE0 (REGION_BASE0),
        .ALIAS_BASE0  (ALIAS_BASE0),
        .REGION_BASE1 (REGION_BASE1),
        .ALIAS_BASE1  (ALIAS_BASE1)
    ) u_decode (
        .addr (s_addr),
        .dec  (dec)
    );

    assign lane_word = (state == ST_FETCH) ? m_rdata : hold;

    bb_bit_lane u_lane (
        .word_in (lane_word),
        .idx     (cap_idx),
        .new_val (cap_wdata[0]),
        .picked  (lane_pick),
        .merged  (lane_merge)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Request capture and response data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr  <= '0;
            cap_word  <= '0;
            cap_idx   <= '0;
            cap_we    <= 1'b0;
            cap_byte  <= 1'b0;
            cap_wdata <= '0;
            hold      <= '0;
            resp      <= '0;
        end else begin
            if (state == ST_IDLE && s_req) begin
                cap_addr  <= s_addr;
                cap_word  <= dec.word_addr;
                cap_idx   <= dec.bit_idx;
                cap_we    <= s_we;
                cap_byte  <= s_byte;
                cap_wdata <= s_wdata;
            end
            if (state == ST_FORWARD && m_ready) begin
                resp <= m_rdata;
            end
            if (state == ST_FETCH && m_ready) begin
                hold <= m_rdata;
                resp <= lane_pick;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (s_req) begin
                    if (dec.alias_hit && dec.misaligned) begin
                        state_nx = ST_FAULT;
                    end else if (dec.alias_hit) begin
                        state_nx = ST_FETCH;
                    end else begin
                        state_nx = ST_FORWARD;
                    end
                end
            end
            ST_FORWARD: if (m_ready) state_nx = ST_DONE;
            ST_FETCH:   if (m_ready) state_nx = cap_we ? ST_MODIFY : ST_DONE;
            ST_MODIFY:  if (m_ready) state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            ST_FAULT:   state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        s_ready = 1'b0;
        s_rdata = '0;
        s_err   = 1'b0;
        m_req   = 1'b0;
        m_we    = 1'b0;
        m_byte  = 1'b0;
        m_lock  = 1'b0;
        m_addr  = '0;
        m_wdata = '0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_FORWARD: begin
                m_req   = 1'b1;
                m_we    = cap_we;
                m_byte  = cap_byte;
                m_addr  = cap_addr;
                m_wdata = cap_wdata;
            end
            ST_FETCH: begin
                m_req  = 1'b1;
                m_lock = cap_we;
                m_addr = cap_word;
            end
            ST_MODIFY: begin
                m_req   = 1'b1;
                m_we    = 1'b1;
                m_lock  = 1'b1;
                m_addr  = cap_word;
                m_wdata = lane_merge;
            end
            ST_DONE: begin
                s_ready = 1'b1;
                s_rdata = resp;
            end
            ST_FAULT: begin
                s_ready = 1'b1;
                s_err   = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/bb_bridge_chk.sv
module bb_bridge_chk
    import bb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             s_ready,
    input logic             s_err,
    input logic             m_req,
    input logic             m_we,
    input logic             m_lock,
    input logic [BB_AW-1:0] m_addr,
    input logic             m_ready
);

    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);

    // R7
    err_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_err |-> s_ready);

    // R5
    lock_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_lock |-> m_req);

    // R5
    locked_read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_lock && !m_we && m_ready) |=> (m_lock && m_req && m_we));

    // R5
    unlock_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m_lock) |-> $past(m_we && m_ready));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ready) |=> (m_req && $stable(m_addr) && $stable(m_we)));

endmodule

bind bb_bridge bb_bridge_chk u_chk (.*);

// File: tb/bb_bridge_test.sv
`timescale 1ns/1ps
module bb_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_req = 1'b0;
    logic        s_we = 1'b0;
    logic        s_byte = 1'b0;
    logic [31:0] s_addr = '0;
    logic [31:0] s_wdata = '0;
    logic        s_ready;
    logic [31:0] s_rdata;
    logic        s_err;
    logic        m_req;
    logic        m_we;
    logic        m_byte;
    logic        m_lock;
    logic [31:0] m_addr;
    logic [31:0] m_wdata;
    logic        m_ready = 1'b0;
    logic [31:0] m_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int wr_cnt = 0;
    int acc_cnt = 0;
    int gap_cnt = 0;
    logic mon_en = 1'b0;
    logic intr_go = 1'b0;
    logic intr_done = 1'b0;
    logic [31:0] intr_addr = 32'h2000_0040;
    logic [31:0] intr_mask = 32'h0000_0020;

    logic [31:0] mem [logic [31:0]];

    always #2.5 clk = ~clk;

    bb_bridge uut (.*);

    function automatic logic [31:0] rdmem(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Memory model; the competing agent writes whenever the lock is low
    always @(negedge clk) begin
        if (intr_go && !intr_done && !m_lock) begin
            mem[intr_addr] = rdmem(intr_addr) | intr_mask;
            intr_done = 1'b1;
        end
        if (m_ready) begin
            m_ready = 1'b0;
        end else if (m_req) begin
            acc_cnt++;
            if (m_we) begin
                mem[m_addr] = m_wdata;
                wr_cnt++;
            end else begin
                m_rdata = rdmem(m_addr);
            end
            m_ready = 1'b1;
        end
        if (mon_en && m_req && !m_lock) gap_cnt++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic byt, input logic [31:0] addr,
                        input logic [31:0] wdata, output logic [31:0] rd, output logic er);
        s_req = 1'b1; s_we = we; s_byte = byt; s_addr = addr; s_wdata = wdata;
        do @(negedge clk); while (!s_ready);
        rd = s_rdata; er = s_err;
        s_req = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic        byt;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        chk;
        logic [31:0] exp;
        logic        err;
        logic [15:0] tag;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 32'h2200_000C, 32'h0000_0001, 1'b0, 32'h0,          1'b0, "R3"},
        '{1'b0, 1'b0, 32'h2000_0000, 32'h0,          1'b1, 32'h0000_0008, 1'b0, "R1"},
        '{1'b0, 1'b0, 32'h2200_000C, 32'h0,          1'b1, 32'h0000_0001, 1'b0, "R2"},
        '{1'b0, 1'b0, 32'h2200_0008, 32'h0,          1'b1, 32'h0000_0000, 1'b0, "R2"},
        '{1'b1, 1'b1, 32'h2200_003C, 32'h0000_00FF, 1'b0, 32'h0,          1'b0, "R4"},
        '{1'b0, 1'b1, 32'h2200_003C, 32'h0,          1'b1, 32'h0000_0001, 1'b0, "R4"},
        '{1'b1, 1'b0, 32'h2200_000C, 32'hFFFF_FFFE, 1'b0, 32'h0,          1'b0, "R3"},
        '{1'b0, 1'b0, 32'h2000_0000, 32'h0,          1'b1, 32'h0000_8000, 1'b0, "R3"},
        '{1'b0, 1'b0, 32'h4200_027C, 32'h0,          1'b1, 32'h0000_0001, 1'b0, "R1"},
        '{1'b1, 1'b0, 32'h4200_027C, 32'h0,          1'b0, 32'h0,          1'b0, "R3"},
        '{1'b0, 1'b0, 32'h4000_0010, 32'h0,          1'b1, 32'h70F0_0000, 1'b0, "R1"},
        '{1'b0, 1'b0, 32'h2200_0002, 32'h0,          1'b0, 32'h0,          1'b1, "R7"},
        '{1'b1, 1'b0, 32'h1000_0004, 32'hDEAD_BEEF, 1'b0, 32'h0,          1'b0, "R6"},
        '{1'b0, 1'b0, 32'h1000_0004, 32'h0,          1'b1, 32'hDEAD_BEEF, 1'b0, "R6"},
        '{1'b1, 1'b0, 32'h23FF_FFFC, 32'h0000_0001, 1'b0, 32'h0,          1'b0, "R1"},
        '{1'b0, 1'b0, 32'h200F_FFFC, 32'h0,          1'b1, 32'h8000_0000, 1'b0, "R1"},
        '{1'b1, 1'b0, 32'h2400_0000, 32'h0000_0055, 1'b0, 32'h0,          1'b0, "R6"},
        '{1'b0, 1'b0, 32'h2400_0000, 32'h0,          1'b1, 32'h0000_0055, 1'b0, "R6"},
        '{1'b0, 1'b0, 32'h2000_0000, 32'h0,          1'b1, 32'h0000_8000, 1'b0, "R6"},
        '{1'b1, 1'b1, 32'h4200_027D, 32'h0000_0001, 1'b0, 32'h0,          1'b1, "R7"},
        '{1'b0, 1'b0, 32'h4000_0010, 32'h0,          1'b1, 32'h70F0_0000, 1'b0, "R7"}
    };

    initial begin
        repeat (40000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual %0d expected %0d", checks, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        int          w0;
        int          a0;
        mem[32'h2000_0000] = 32'h0;
        mem[32'h4000_0010] = 32'hF0F0_0000;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 s_ready", {31'b0, s_ready}, 32'h0);
        check("R9 s_err",   {31'b0, s_err},   32'h0);
        check("R9 m_req",   {31'b0, m_req},   32'h0);
        check("R9 m_lock",  {31'b0, m_lock},  32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            w0 = wr_cnt;
            a0 = acc_cnt;
            xfer(VEC[i].we, VEC[i].byt, VEC[i].addr, VEC[i].wdata, rd, er);
            check($sformatf("%s err v%0d", VEC[i].tag, i), {31'b0, er}, {31'b0, VEC[i].err});
            if (VEC[i].chk)
                check($sformatf("%s rdata v%0d", VEC[i].tag, i), rd, VEC[i].exp);
            if (!VEC[i].we)
                check($sformatf("R2 no write on read v%0d", i), wr_cnt - w0, 0);
            if (VEC[i].err)
                check($sformatf("R7 no access v%0d", i), acc_cnt - a0, 0);
        end

        // R5: competing update during an alias write must not be lost
        mon_en = 1'b1;
        fork
            xfer(1'b1, 1'b0, 32'h2200_0800, 32'h1, rd, er);
            begin
                do @(negedge clk); while (!m_lock);
                intr_go = 1'b1;
            end
        join
        mon_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 gap cycles", gap_cnt, 0);
        check("R5 intruder ran", {31'b0, intr_done}, 32'h1);
        xfer(1'b0, 1'b0, 32'h2000_0040, 32'h0, rd, er);
        check("R5 merged word", rd, 32'h0000_0021);

        // R8: request held high across a completion
        s_req = 1'b1; s_we = 1'b0; s_byte = 1'b0; s_addr = 32'h2000_0000;
        do @(negedge clk); while (!s_ready);
        check("R8 first rdata", s_rdata, 32'h0000_8000);
        s_addr = 32'h2200_003C;
        @(negedge clk);
        check("R8 ready dropped", {31'b0, s_ready}, 32'h0);
        do @(negedge clk); while (!s_ready);
        check("R8 second rdata", s_rdata, 32'h0000_0001);
        s_req = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R8 no extra ready", {31'b0, s_ready}, 32'h0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule